// File: doc/BRIEF.md
# Wide Fan-In Multiplexer Logic Cell

This block is a single programmable logic cell. It is built from multiplexers rather than from a lookup table. Two wide AND gates and four two-input AND gates act only as select generators for a three-level tree of 2:1 multiplexers:

- Each two-input AND gate picks between a pair of data inputs in one of the four leaf multiplexers.
- Each wide AND gate steers one of the two middle multiplexers.
- One plain select input picks the root.

Four internal nodes of the tree leave the cell as combinational outputs.

Two D flip-flops share one clock. The first captures the root of the tree. The second captures either the lower middle node or a dedicated direct input. A static source-select chooses which, and it may only change while the block is held in reset. Each flip-flop has its own asynchronous set and clear, and clear wins when both are active.

The block reset is active low. It acts at once and is released in step with the clock, so the flip-flops resume loading on the third rising edge after it is removed.

Top module: `lgc_cell`

## Requirements
- R1: `wide_a_o` is 1 exactly when all six bits of `wa_i` are 1, with no clock involved.
- R2: Leaf k (k = 0..3) passes `dat_i[2k+1]` when `sp_i[2k]` and `sp_i[2k+1]` are both 1, and passes `dat_i[2k]` otherwise.
- R3: `upper_o` is leaf 1 when all bits of `wa_i` are 1 and leaf 0 otherwise. `lower_o` is leaf 3 when all bits of `wf_i` are 1 and leaf 2 otherwise.
- R4: `tree_o` equals `lower_o` when `root_sel_i` is 1 and `upper_o` when it is 0.
- R5: On each rising clock edge with no set, clear or reset active, `q_o[0]` takes the value `tree_o` had just before the edge.
- R6: On such an edge `q_o[1]` takes `lower_o` when `src_dir_i` is 0 and `direct_i` when it is 1. `src_dir_i` is a static tie-off that changes only while `rst_n` is low.
- R7: `set_i[k]` high drives `q_o[k]` to 1 at once, without waiting for a clock edge.
- R8: `clr_i[k]` high drives `q_o[k]` to 0 at once, and it overrides `set_i[k]`.
- R9: `rst_n` low clears both flip-flops at once, overriding set. After `rst_n` rises, the flip-flops stay clear through two rising edges and first load on the third.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both flip-flops |
| rst_n | input | 1 | Asynchronous active-low block reset, released synchronously |
| wa_i | input | 6 | Inputs of the wide AND steering the upper middle multiplexer |
| wf_i | input | 6 | Inputs of the wide AND steering the lower middle multiplexer |
| sp_i | input | 8 | Select pairs: bits 2k and 2k+1 feed the two-input AND of leaf k |
| dat_i | input | 8 | Leaf data: bits 2k and 2k+1 are the two choices of leaf k |
| root_sel_i | input | 1 | Root multiplexer select: 1 picks the lower node |
| direct_i | input | 1 | Dedicated direct data input for the second flip-flop |
| src_dir_i | input | 1 | Static source select of the second flip-flop: 1 picks `direct_i` |
| set_i | input | 2 | Asynchronous set, one bit per flip-flop |
| clr_i | input | 2 | Asynchronous clear, one bit per flip-flop; wins over set |
| wide_a_o | output | 1 | AND of all `wa_i` bits |
| upper_o | output | 1 | Upper middle multiplexer output |
| lower_o | output | 1 | Lower middle multiplexer output |
| tree_o | output | 1 | Root multiplexer output |
| q_o | output | 2 | Registered outputs of the two flip-flops |

## Verification
The four combinational results are due in the same cycle as their inputs. The bench drives inputs on the falling edge and compares them one time unit later, before the next rising edge. Each registered result is due right after the next rising edge, so the bench compares it one time unit after that edge against the value the tree held before it. Set and clear act without a clock and are compared one time unit after they are driven. The reset release is checked edge by edge: the bench expects the flip-flops to remain at 0 after the first and second rising edges and to load on the third.

// File: rtl/lgc_pkg.sv
package lgc_pkg;
  parameter int WIDE_W = 6;
  parameter int N_LEAF = 4;
  parameter int N_FF   = 2;
  localparam int SP_W  = 2 * N_LEAF;
  localparam int RST_STAGES = 2;
endpackage

// File: rtl/lgc_mux_tree.sv
module lgc_mux_tree
  import lgc_pkg::*;
(
  input  logic [WIDE_W-1:0] wa_i,
  input  logic [WIDE_W-1:0] wf_i,
  input  logic [SP_W-1:0]   sp_i,
  input  logic [SP_W-1:0]   dat_i,
  input  logic              root_sel_i,
  output logic              wide_a_o,
  output logic              upper_o,
  output logic              lower_o,
  output logic              tree_o
);
  logic [N_LEAF-1:0] leaf_sel;
  logic [N_LEAF-1:0] leaf_out;
  logic              wide_f;

  // two-input AND select generators and first-level multiplexers
  genvar k;
  generate
    for (k = 0; k < N_LEAF; k++) begin : g_leaf
      assign leaf_sel[k] = sp_i[2*k] & sp_i[2*k+1];
      assign leaf_out[k] = leaf_sel[k] ? dat_i[2*k+1] : dat_i[2*k];
    end
  endgenerate

  // wide AND selects for the middle level
  assign wide_a_o = &wa_i;
  assign wide_f   = &wf_i;

  always_comb begin
    upper_o = wide_a_o ? leaf_out[1] : leaf_out[0];
    lower_o = wide_f   ? leaf_out[3] : leaf_out[2];
    tree_o  = root_sel_i ? lower_o : upper_o;
  end
endmodule

// File: rtl/lgc_rst_sync.sv
module lgc_rst_sync
  import lgc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [RST_STAGES-1:0] stage_q;
  logic [RST_STAGES-1:0] stage_d;

  always_comb begin
    stage_d = {stage_q[RST_STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= '0;
    else        stage_q <= stage_d;
  end

  assign rst_sync_n = stage_q[RST_STAGES-1];
endmodule

// File: rtl/lgc_sr_ff.sv
module lgc_sr_ff (
  input  logic clk,
  input  logic clr_i,
  input  logic set_i,
  input  logic d_i,
  output logic q_o
);
  // clear has priority over set; both act without the clock
  always_ff @(posedge clk or posedge clr_i or posedge set_i) begin
    if (clr_i)      q_o <= 1'b0;
    else if (set_i) q_o <= 1'b1;
    else            q_o <= d_i;
  end
endmodule

// File: rtl/lgc_cell.sv
module lgc_cell
  import lgc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WIDE_W-1:0] wa_i,
  input  logic [WIDE_W-1:0] wf_i,
  input  logic [SP_W-1:0]   sp_i,
  input  logic [SP_W-1:0]   dat_i,
  input  logic              root_sel_i,
  input  logic              direct_i,
  input  logic              src_dir_i,
  input  logic [N_FF-1:0]   set_i,
  input  logic [N_FF-1:0]   clr_i,
  output logic              wide_a_o,
  output logic              upper_o,
  output logic              lower_o,
  output logic              tree_o,
  output logic [N_FF-1:0]   q_o
);
  logic            rst_sync_n;
  logic [N_FF-1:0] ff_d;
  logic [N_FF-1:0] ff_clr;

  lgc_mux_tree u_tree (
    .wa_i       (wa_i),
    .wf_i       (wf_i),
    .sp_i       (sp_i),
    .dat_i      (dat_i),
    .root_sel_i (root_sel_i),
    .wide_a_o   (wide_a_o),
    .upper_o    (upper_o),
    .lower_o    (lower_o),
    .tree_o     (tree_o)
  );

  lgc_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  // data sources: first register from the root, second from the static pick
  always_comb begin
    ff_d[0] = tree_o;
    ff_d[1] = src_dir_i ? direct_i : lower_o;
  end

  genvar n;
  generate
    for (n = 0; n < N_FF; n++) begin : g_ff
      assign ff_clr[n] = clr_i[n] | ~rst_sync_n;
      lgc_sr_ff u_ff (
        .clk   (clk),
        .clr_i (ff_clr[n]),
        .set_i (set_i[n]),
        .d_i   (ff_d[n]),
        .q_o   (q_o[n])
      );
    end
  endgenerate
endmodule

// File: rtl/lgc_cell_chk.sv
module lgc_cell_chk
  import lgc_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              direct_i,
  input logic              src_dir_i,
  input logic [N_FF-1:0]   set_i,
  input logic [N_FF-1:0]   clr_i,
  input logic              lower_o,
  input logic              tree_o,
  input logic [N_FF-1:0]   q_o
);
  logic [1:0] since_rst;
  logic       ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               since_rst <= 2'd0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end
  assign ready = (since_rst == 2'd3);

  AST_Q0_LOADS_ROOT: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && !set_i[0] && !clr_i[0]) |=>
      (set_i[0] || clr_i[0] || q_o[0] == $past(tree_o))); // R5

  AST_Q1_LOADS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && !set_i[1] && !clr_i[1]) |=>
      (set_i[1] || clr_i[1] ||
       q_o[1] == ($past(src_dir_i) ? $past(direct_i) : $past(lower_o)))); // R6

  AST_SRC_STATIC: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> $stable(src_dir_i)); // R6

  AST_SET_FORCES_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && set_i[0] && !clr_i[0]) |-> q_o[0]); // R7

  AST_CLR_WINS_Q0: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i[0] |-> !q_o[0]); // R8

  AST_CLR_WINS_Q1: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i[1] |-> !q_o[1]); // R8
endmodule

bind lgc_cell lgc_cell_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .direct_i  (direct_i),
  .src_dir_i (src_dir_i),
  .set_i     (set_i),
  .clr_i     (clr_i),
  .lower_o   (lower_o),
  .tree_o    (tree_o),
  .q_o       (q_o)
);

// File: tb/tb_lgc_cell.sv
module tb_lgc_cell;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [5:0] wa_i, wf_i;
  logic [7:0] sp_i, dat_i;
  logic       root_sel_i, direct_i, src_dir_i;
  logic [1:0] set_i, clr_i;
  logic       wide_a_o, upper_o, lower_o, tree_o;
  logic [1:0] q_o;

  int n_cmp = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  lgc_cell dut (
    .clk(clk), .rst_n(rst_n), .wa_i(wa_i), .wf_i(wf_i), .sp_i(sp_i),
    .dat_i(dat_i), .root_sel_i(root_sel_i), .direct_i(direct_i),
    .src_dir_i(src_dir_i), .set_i(set_i), .clr_i(clr_i),
    .wide_a_o(wide_a_o), .upper_o(upper_o), .lower_o(lower_o),
    .tree_o(tree_o), .q_o(q_o)
  );

  typedef struct packed {
    logic [5:0] wa;
    logic [5:0] wf;
    logic [7:0] sp;
    logic [7:0] dat;
    logic       root;
  } vec_t;

  localparam vec_t VECS [12] = '{
    '{6'h00, 6'h00, 8'h00, 8'h00, 1'b0},
    '{6'h3F, 6'h00, 8'h0C, 8'h08, 1'b0},
    '{6'h3E, 6'h00, 8'h03, 8'h02, 1'b0},
    '{6'h1F, 6'h3F, 8'hC0, 8'h80, 1'b1},
    '{6'h3F, 6'h3F, 8'hFF, 8'hAA, 1'b1},
    '{6'h3F, 6'h3F, 8'hFF, 8'h55, 1'b0},
    '{6'h00, 6'h3F, 8'h30, 8'h10, 1'b1},
    '{6'h2A, 6'h15, 8'h55, 8'hFF, 1'b1},
    '{6'h3F, 6'h3E, 8'h0F, 8'h0A, 1'b0},
    '{6'h00, 6'h00, 8'hAA, 8'h0F, 1'b1},
    '{6'h3F, 6'h3F, 8'hCC, 8'hC3, 1'b1},
    '{6'h3F, 6'h00, 8'h3C, 8'h24, 1'b0}
  };

  // reference: {tree, lower, upper, wide_a}, built from R1..R4
  function automatic logic [3:0] ref_comb(vec_t v);
    logic [3:0] lf;
    logic up, dn;
    for (int k = 0; k < 4; k++)
      lf[k] = (v.sp[2*k] && v.sp[2*k+1]) ? v.dat[2*k+1] : v.dat[2*k];
    up = (v.wa == 6'h3F) ? lf[1] : lf[0];
    dn = (v.wf == 6'h3F) ? lf[3] : lf[2];
    return {(v.root ? dn : up), dn, up, (v.wa == 6'h3F)};
  endfunction

  task automatic chk(string req, logic [3:0] got, logic [3:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b at %0t", req, got, exp, $time);
    end
  endtask

  task automatic drive(vec_t v);
    wa_i = v.wa; wf_i = v.wf; sp_i = v.sp; dat_i = v.dat; root_sel_i = v.root;
  endtask

  // apply vector at falling edge, check comb, then check registers after edge
  task automatic run_vec(vec_t v, logic dir);
    logic [3:0] e;
    @(negedge clk);
    drive(v);
    direct_i = dir;
    #1;
    e = ref_comb(v);
    chk("R1 wide AND", {3'b0, wide_a_o}, {3'b0, e[0]});
    chk("R2/R3 middle nodes", {2'b0, lower_o, upper_o}, {2'b0, e[2], e[1]});
    chk("R4 root", {3'b0, tree_o}, {3'b0, e[3]});
    @(posedge clk);
    #1;
    chk("R5 q0 loads root", {3'b0, q_o[0]}, {3'b0, e[3]});
    chk("R6 q1 source", {3'b0, q_o[1]}, {3'b0, (src_dir_i ? dir : e[2])});
  endtask

  task automatic reset_with_src(logic src);
    @(negedge clk);
    rst_n = 1'b0;
    src_dir_i = src;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(200000 * 10);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; src_dir_i = 1'b0; direct_i = 1'b0;
    set_i = 2'b00; clr_i = 2'b00;
    drive(VECS[0]);
    #2;
    chk("R9 reset state", {2'b0, q_o}, 4'b0000);
    // set is overridden while reset is held
    set_i = 2'b11;
    #1;
    chk("R9 reset beats set", {2'b0, q_o}, 4'b0000);
    set_i = 2'b00;
    @(negedge clk);
    @(negedge clk);
    dat_i = 8'hFF; sp_i = 8'h00; root_sel_i = 1'b0;
    rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R9 held after edge 1", {3'b0, q_o[0]}, 4'b0000);
    @(posedge clk); #1;
    chk("R9 held after edge 2", {3'b0, q_o[0]}, 4'b0000);
    @(posedge clk); #1;
    chk("R9 loads on edge 3", {3'b0, q_o[0]}, 4'b0001);

    // table walk, second flip-flop from the lower node
    for (int i = 0; i < 12; i++) run_vec(VECS[i], 1'b0);

    // random patterns
    for (int i = 0; i < 200; i++) begin
      vec_t rv;
      rv.wa   = ($urandom % 4 == 0) ? 6'h3F : 6'($urandom);
      rv.wf   = ($urandom % 4 == 0) ? 6'h3F : 6'($urandom);
      rv.sp   = 8'($urandom);
      rv.dat  = 8'($urandom);
      rv.root = 1'($urandom);
      run_vec(rv, 1'($urandom));
    end

    // second flip-flop from the direct input (static pick changed under reset)
    reset_with_src(1'b1);
    for (int i = 0; i < 12; i++) run_vec(VECS[i], 1'(i % 2));

    // R7 asynchronous set: tree low, so only set can raise q
    @(negedge clk);
    drive(VECS[0]); direct_i = 1'b0;
    @(posedge clk); #1;
    @(negedge clk);
    set_i = 2'b11;
    #1;
    chk("R7 async set", {2'b0, q_o}, 4'b0011);
    @(posedge clk); #1;
    set_i = 2'b00;
    @(posedge clk); #1;
    chk("R7 set released, loads D", {2'b0, q_o}, 4'b0000);

    // R8 clear, and clear over set: tree high, so only clear can drop q
    @(negedge clk);
    dat_i = 8'hFF; direct_i = 1'b1;
    @(posedge clk); #1;
    chk("R8 precondition high", {2'b0, q_o}, 4'b0011);
    @(negedge clk);
    clr_i = 2'b01;
    #1;
    chk("R8 async clear q0", {2'b0, q_o}, 4'b0010);
    set_i = 2'b11; clr_i = 2'b11;
    #1;
    chk("R8 clear wins over set", {2'b0, q_o}, 4'b0000);
    @(posedge clk); #1;
    chk("R8 clear holds across edge", {2'b0, q_o}, 4'b0000);
    set_i = 2'b00; clr_i = 2'b00;
    @(posedge clk); #1;
    chk("R5/R6 resume after clear", {2'b0, q_o}, 4'b0011);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule